// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets clocked logic use an external asynchronous static RAM of 1M words by 4 bits. Requests arrive on a simple port: valid, ready, a write flag, a 20-bit word address and 4-bit write data. Read results come back as 4-bit data with a one-cycle valid strobe. On the memory side the block drives active-low chip select, output enable and write enable, plus the address bus. The bidirectional data pins are modelled as three signals: data out, data in and a drive enable.

Each memory timing figure is given in nanoseconds and turned into a whole number of clock cycles by rounding up against a clock-period parameter. The defaults assume a 10 ns clock. This gives a 2-cycle read access, a 2-cycle write pulse and a 1-cycle turnaround.

A write opens chip select and write enable on the same edge, so the memory keeps its outputs high impedance for the whole write. Both strobes close together on a later edge. The address register loads only while chip select is high, so the address never moves inside an open window. After every access the block waits for a bus turnaround gap before it accepts the next request.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, req_ready is 1, sram_cs_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0 and rsp_valid is 0.
- R2: A read holds sram_cs_n=0, sram_oe_n=0 and sram_we_n=1 for RD_CYC cycles (default 2). sram_dq_in is captured on the last of those cycles and returned on rsp_rdata with rsp_valid=1 for exactly one cycle, in the cycle that follows the access.
- R3: A write pulls sram_cs_n and sram_we_n low on the same edge and raises both on the same edge WP_CYC cycles later (default 2). sram_oe_n stays 1 throughout, and the word on sram_dq_out during the window is the one stored at sram_addr.
- R4: sram_addr changes only in cycles where sram_cs_n is 1. It stays stable for the whole time chip select is low.
- R5: sram_dq_oe is 1 exactly while sram_we_n is low, plus one hold cycle after it (default 3 cycles per write). It is never 1 while sram_oe_n is 0.
- R6: Between sram_dq_oe falling and a later fall of sram_oe_n, sram_dq_oe stays low for at least HZ_CYC cycles (default 1). In the same way, sram_oe_n stays high for at least HZ_CYC cycles before sram_dq_oe rises.
- R7: req_ready is low from the cycle after a request is accepted until its cycle and turnaround are complete. With the defaults that is RD_CYC+HZ_CYC = 3 cycles for a read and WP_CYC+1+HZ_CYC = 4 cycles for a write.
- R8: A read returns the data of the most recent write to the same full 20-bit address, including a read issued immediately after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_rdata | output | 4 | Read data |
| rsp_valid | output | 1 | One-cycle strobe for rsp_rdata |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_addr | output | 20 | Memory address |
| sram_dq_out | output | 4 | Data driven toward the memory |
| sram_dq_in | input | 4 | Data returned by the memory |
| sram_dq_oe | output | 1 | Enables the controller's data drivers |

## Verification
The bench runs an exhaustive sweep over 256 addresses that spread across both the high and the low address bits. It writes every address with an arithmetically derived nibble, and after the sweep it reads every address back. A memory model that checks full-address tags separates correct address routing from aliasing. The sweep is followed by interleaved write-then-read pairs to a single address, which separate a write that commits at the closing edge of the window from one that commits late. During every operation the bench measures the busy time, the position of the response strobe, the window length, the drive cycles and the turnaround gaps, so timing errors are told apart from data errors.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 12,
  parameter int T_WC_NS       = 12,
  parameter int T_HZ_NS       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_valid,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);
  localparam int RD_RAW = (T_RC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WP_RAW = (T_WC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int HZ_RAW = (T_HZ_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RD_CYC = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WP_CYC = (WP_RAW < 1) ? 1 : WP_RAW;
  localparam int HZ_CYC = (HZ_RAW < 1) ? 1 : HZ_RAW;
  localparam int MAX_AB = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_C  = (MAX_AB > HZ_CYC) ? MAX_AB : HZ_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_HOLD, S_TA} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sram_cs_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rsp_rdata   <= '0;
      rsp_valid   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          sram_addr   <= req_addr;
          sram_dq_out <= req_wdata;
          cnt         <= '0;
          sram_cs_n   <= 1'b0;
          if (req_write) begin
            state      <= S_WR;
            sram_we_n  <= 1'b0;
            sram_dq_oe <= 1'b1;
          end else begin
            state     <= S_RD;
            sram_oe_n <= 1'b0;
          end
        end
        S_RD: if (cnt == CNT_W'(RD_CYC - 1)) begin
          rsp_rdata <= sram_dq_in;
          rsp_valid <= 1'b1;
          sram_cs_n <= 1'b1;
          sram_oe_n <= 1'b1;
          cnt       <= '0;
          state     <= S_TA;
        end else cnt <= cnt + 1'b1;
        S_WR: if (cnt == CNT_W'(WP_CYC - 1)) begin
          sram_we_n <= 1'b1;
          sram_cs_n <= 1'b1;
          state     <= S_HOLD;
        end else cnt <= cnt + 1'b1;
        S_HOLD: begin
          sram_dq_oe <= 1'b0;
          cnt        <= '0;
          state      <= S_TA;
        end
        S_TA: if (cnt == CNT_W'(HZ_CYC - 1)) state <= S_IDLE;
              else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0; else live <= 1'b1;

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_strobes_open_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $fell(we_n)) |-> $fell(cs_n));
  assert_strobes_close_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(we_n)) |-> $rose(cs_n));
  assert_no_oe_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !cs_n && !$past(cs_n)) |-> $stable(addr));
  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  assert_drive_covers_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $fell(oe_n)) |-> !$past(dq_oe));
  assert_idle_when_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && !dq_oe));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .cs_n(sram_cs_n), .oe_n(sram_oe_n), .we_n(sram_we_n), .addr(sram_addr),
  .dq_oe(sram_dq_oe));

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int RD_CYC = 2, WP_CYC = 2, HZ_CYC = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid, cs_n, oe_n, we_n, dq_oe;
  logic [3:0] rsp_rdata, dq_out, dq_in;
  logic [19:0] sram_addr;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .sram_cs_n(cs_n),
    .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_addr(sram_addr),
    .sram_dq_out(dq_out), .sram_dq_in(dq_in), .sram_dq_oe(dq_oe));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model with full-address tags
  logic [3:0]  mem [256];
  logic [19:0] tag [256];
  assign dq_in = (!cs_n && !oe_n && we_n)
               ? ((tag[sram_addr[7:0]] == sram_addr) ? mem[sram_addr[7:0]] : ~mem[sram_addr[7:0]])
               : 4'h0;

  bit   open_q = 0;
  int   win_len = 0, drv_len = 0, oe_len = 0, since_drv = 99, since_oe = 99;
  logic [19:0] w_addr;
  logic [3:0]  w_data;
  int v_win = 0, v_oe_w = 0, v_addr = 0, v_drv = 0, v_ta = 0, v_rdwin = 0, v_fight = 0;
  logic cs_q = 1, oe_q = 1, dqoe_q = 0;
  logic [19:0] addr_q = '0;

  always @(posedge clk) if (rst_n) begin
    bit open;
    open = !cs_n && !we_n;
    if (open) begin
      win_len++;
      w_addr = sram_addr; w_data = dq_out;
      if (!oe_n) v_oe_w++;
      if (!dq_oe) v_drv++;
    end
    if (!cs_n && !cs_q && sram_addr != addr_q) v_addr++;
    if (dq_oe && !oe_n) v_fight++;
    if (!open && open_q) begin
      mem[w_addr[7:0]] = w_data; tag[w_addr[7:0]] = w_addr;
      if (win_len != WP_CYC) v_win++;
      win_len = 0;
    end
    if ((cs_n != we_n) && !oe_n == 0 && we_n == 0) v_win++;
    if (dq_oe) drv_len++;
    else if (dqoe_q) begin
      if (drv_len != WP_CYC + 1) v_drv++;
      drv_len = 0;
    end
    if (!oe_n) oe_len++;
    else if (!oe_q) begin
      if (oe_len != RD_CYC) v_rdwin++;
      oe_len = 0;
    end
    if (!oe_n && oe_q && since_drv < HZ_CYC) v_ta++;
    if (dq_oe && !dqoe_q && since_oe < HZ_CYC) v_ta++;
    since_drv = dq_oe ? 0 : since_drv + 1;
    since_oe  = !oe_n ? 0 : since_oe + 1;
    open_q = open; cs_q = cs_n; oe_q = oe_n; dqoe_q = dq_oe; addr_q = sram_addr;
  end

  task automatic op(bit w, logic [19:0] a, logic [3:0] d, output logic [3:0] rd);
    int busy, nv, at;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    busy = 0; nv = 0; at = -1; rd = 4'h0;
    while (!req_ready && busy < 50) begin
      if (rsp_valid) begin nv++; at = busy; rd = rsp_rdata; end
      busy++;
      @(negedge clk);
    end
    if (rsp_valid) nv++;
    if (w) begin
      check("R7 write busy cycles", busy, WP_CYC + 1 + HZ_CYC);
      check("R2 no response on write", nv, 0);
    end else begin
      check("R7 read busy cycles", busy, RD_CYC + HZ_CYC);
      check("R2 one response pulse", nv, 1);
      check("R2 response cycle", at, RD_CYC);
    end
  endtask

  function automatic logic [19:0] addr_of(int i);
    return {i[7:0], 4'h0, i[7:0] ^ 8'hA5};
  endfunction
  function automatic logic [3:0] data_of(int i);
    return 4'((i * 5 + 3) % 16);
  endfunction

  initial begin
    logic [3:0] r;
    for (int i = 0; i < 256; i++) begin mem[i] = 4'h0; tag[i] = '1; end
    repeat (3) @(negedge clk);
    check("R1 ready", int'(req_ready), 1);
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 oe_n", int'(oe_n), 1);
    check("R1 we_n", int'(we_n), 1);
    check("R1 dq_oe", int'(dq_oe), 0);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) op(1, addr_of(i), data_of(i), r);
    for (int i = 0; i < 256; i++) begin
      op(0, addr_of(i), 4'h0, r);
      check("R8 sweep readback", int'(r), int'(data_of(i)));
    end
    for (int i = 0; i < 16; i++) begin
      op(1, addr_of(7), 4'(15 - i), r);
      op(0, addr_of(7), 4'h0, r);
      check("R8 write-then-read", int'(r), 15 - i);
    end
    repeat (3) @(negedge clk);
    check("R3 window length and strobe pairing", v_win, 0);
    check("R3 oe_n high during write", v_oe_w, 0);
    check("R4 address stable under chip select", v_addr, 0);
    check("R5 drive window length", v_drv, 0);
    check("R5 no bus fight", v_fight, 0);
    check("R2 read window length", v_rdwin, 0);
    check("R6 turnaround gaps", v_ta, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R7 actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule